// File: doc/BRIEF.md
# Consecutive-Period PWM Fault Latch

This block guards one PWM channel with two outputs, A and B. Four fault lines arrive from outside: a cycle-by-cycle current-limit line, a line that acts on both outputs, a line for output A only and a line for output B only. Each line is synchronized and turned into single-cycle events on its rising edges. A per-source counter then tracks how many PWM periods in a row, bounded by a period strobe, held at least one event. When a faulted period arrives while the counter has already reached its programmed limit, the outputs tied to that source are forced low. They stay low until the channel enable is dropped and raised again.

Events on the A, B and both-output lines also set sticky status flags. A status read strobe clears these flags, and each flag can raise the interrupt request through its own enable bit. All pins are plain level or strobe controls. The block carries no data stream, so it has no valid/ready handshake and applies no back-pressure. The PWM waveforms pass straight through, gated by the channel enable and the shutdown state.

Top module: `pwm_fault_latch`

## Requirements
- R1: The current-limit source counts and shuts down only while `cl_en` is 1. The A, B and both-output sources count, shut down and set flags only while `grp_en` is 1. A disabled source has no effect on the outputs or the flags.
- R2: Each fault input passes through a two-flop synchronizer. A rising edge becomes one event, and that event is acted on at the third clock edge after the input rises. Each source owns a 5-bit counter and a 5-bit limit.
- R3: A counter advances by at most one per PWM period, however many events fall in that period. An event in the strobe cycle belongs to the period that is ending.
- R4: When a period ends with no enabled event on a source, that source's counter returns to zero.
- R5: A source trips when an enabled event is the first of its period and the counter is already at or above the limit. A limit of 0 trips on the first faulted period, a limit of N trips in the (N+1)-th consecutive faulted period, and a limit of 31 trips in the 32nd.
- R6: A trip on the A source forces `pwm_a_out` low. A trip on the B source forces `pwm_b_out` low. A trip on the both-output source or the current-limit source forces both outputs low. Without a trip and with `chan_en` at 1, each output equals its input. With `chan_en` at 0, both outputs are low.
- R7: A trip stays latched through any number of clean periods. It clears, together with the counters, only while `chan_en` is 0, and normal output returns once `chan_en` is 1 again.
- R8: `stat_flags` bit 0 (A), bit 1 (B) and bit 2 (both-output) are set by an enabled event on that source. A one-cycle `stat_rd` pulse clears all three. After reset the flags are 0.
- R9: If `stat_rd` and a new flag event fall in the same cycle, the flag ends up set.
- R10: `irq` is 1 exactly when some flag bit is 1 and the matching bit of `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; low clears the trips and counters and forces the outputs low |
| period_strobe | input | 1 | One-cycle pulse on the last cycle of each PWM period |
| flt_cl_in | input | 1 | Current-limit fault line, asynchronous |
| flt_ab_in | input | 1 | Both-output fault line, asynchronous |
| flt_a_in | input | 1 | Output-A fault line, asynchronous |
| flt_b_in | input | 1 | Output-B fault line, asynchronous |
| cl_en | input | 1 | Enable for the current-limit source |
| grp_en | input | 1 | Shared enable for the A, B and both-output sources |
| lim_cl | input | 5 | Limit for the current-limit source |
| lim_ab | input | 5 | Limit for the both-output source |
| lim_a | input | 5 | Limit for the A source |
| lim_b | input | 5 | Limit for the B source |
| pwm_a_in | input | 1 | Raw PWM output A |
| pwm_b_in | input | 1 | Raw PWM output B |
| pwm_a_out | output | 1 | Gated PWM output A |
| pwm_b_out | output | 1 | Gated PWM output B |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| stat_flags | output | 3 | Sticky flags: bit 0 A, bit 1 B, bit 2 both-output |
| irq_en | input | 3 | Per-flag interrupt enables, same bit order |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. A counter never moves more than one step or back to zero. A counter stays still once its period has seen an event. A trip holds while the channel is enabled and is gone after a disabled cycle. A tripped source always has its outputs low. A flag rises only after a set, and a set always leaves its flag high. The bench scenarios show the behaviours that need a count over many periods: the exact period in which a limit of 0, 1, 2 or 31 trips, the reset of a run by a clean period, and the effect of the enable bits. They also show the read-versus-set race at its precise cycle.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  localparam int NSRC = 4;
  localparam int NFLAG = 3;
  typedef enum int {
    SRC_CL = 0,
    SRC_AB = 1,
    SRC_A  = 2,
    SRC_B  = 3
  } fault_src_e;
endpackage

// File: rtl/pfl_sync_edge.sv
module pfl_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

  // R2: an event lasts a single cycle
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pfl_period_cnt.sv
module pfl_period_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             strobe,
  input  logic             ev,
  input  logic [CNT_W-1:0] limit,
  output logic             tripped
);
  logic [CNT_W-1:0] cnt;
  logic             seen;
  logic             first;

  assign first = ev & ~seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !chan_en) begin
      cnt     <= '0;
      seen    <= 1'b0;
      tripped <= 1'b0;
    end else begin
      if (first && cnt >= limit) tripped <= 1'b1;
      if (strobe) begin
        seen <= 1'b0;
        if (!seen && !ev)              cnt <= '0;
        else if (first && cnt < limit) cnt <= cnt + 1'b1;
      end else if (first) begin
        seen <= 1'b1;
        if (cnt < limit) cnt <= cnt + 1'b1;
      end
    end
  end

  assert_step_or_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));
  assert_once_per_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !strobe && chan_en) |=> $stable(cnt));
  assert_trip_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && chan_en) |=> tripped);
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!tripped && cnt == '0));
endmodule

// File: rtl/pfl_status.sv
module pfl_status #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic          rd,
  input  logic [NF-1:0] irq_en,
  output logic [NF-1:0] flags,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (rd ? '0 : flags) | set;
  end

  assign irq = |(flags & irq_en);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set)));
  assert_rise_needs_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(set)) == '0));
endmodule

// File: rtl/pwm_fault_latch.sv
module pwm_fault_latch
  import pfl_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             period_strobe,
  input  logic             flt_cl_in,
  input  logic             flt_ab_in,
  input  logic             flt_a_in,
  input  logic             flt_b_in,
  input  logic             cl_en,
  input  logic             grp_en,
  input  logic [CNT_W-1:0] lim_cl,
  input  logic [CNT_W-1:0] lim_ab,
  input  logic [CNT_W-1:0] lim_a,
  input  logic [CNT_W-1:0] lim_b,
  input  logic             pwm_a_in,
  input  logic             pwm_b_in,
  output logic             pwm_a_out,
  output logic             pwm_b_out,
  input  logic             stat_rd,
  output logic [NFLAG-1:0] stat_flags,
  input  logic [NFLAG-1:0] irq_en,
  output logic             irq
);
  logic [NSRC-1:0]  raw;
  logic [NSRC-1:0]  src_en;
  logic [NSRC-1:0]  rise;
  logic [NSRC-1:0]  ev;
  logic [NSRC-1:0]  trip;
  logic [CNT_W-1:0] lim_vec [NSRC];
  logic             kill_a, kill_b;

  assign raw[SRC_CL]    = flt_cl_in;
  assign raw[SRC_AB]    = flt_ab_in;
  assign raw[SRC_A]     = flt_a_in;
  assign raw[SRC_B]     = flt_b_in;
  assign src_en[SRC_CL] = cl_en;
  assign src_en[SRC_AB] = grp_en;
  assign src_en[SRC_A]  = grp_en;
  assign src_en[SRC_B]  = grp_en;
  assign lim_vec[SRC_CL] = lim_cl;
  assign lim_vec[SRC_AB] = lim_ab;
  assign lim_vec[SRC_A]  = lim_a;
  assign lim_vec[SRC_B]  = lim_b;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    pfl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[i]),
      .rise (rise[i])
    );
    assign ev[i] = rise[i] & src_en[i];
    pfl_period_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .chan_en(chan_en),
      .strobe (period_strobe),
      .ev     (ev[i]),
      .limit  (lim_vec[i]),
      .tripped(trip[i])
    );
  end

  assign kill_a    = trip[SRC_CL] | trip[SRC_AB] | trip[SRC_A];
  assign kill_b    = trip[SRC_CL] | trip[SRC_AB] | trip[SRC_B];
  assign pwm_a_out = pwm_a_in & chan_en & ~kill_a;
  assign pwm_b_out = pwm_b_in & chan_en & ~kill_b;

  pfl_status #(.NF(NFLAG)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({ev[SRC_AB], ev[SRC_B], ev[SRC_A]}),
    .rd    (stat_rd),
    .irq_en(irq_en),
    .flags (stat_flags),
    .irq   (irq)
  );

  assert_a_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip[SRC_A] |-> !pwm_a_out);
  assert_b_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip[SRC_B] |-> !pwm_b_out);
  assert_both_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trip[SRC_AB] || trip[SRC_CL]) |-> (!pwm_a_out && !pwm_b_out));
  assert_cl_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl_en && !trip[SRC_CL] && chan_en) |=> !trip[SRC_CL]);
endmodule

// File: tb/tb_pwm_fault_latch.sv
module tb_pwm_fault_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0, period_strobe = 1'b0;
  logic [3:0] fv = '0;
  logic cl_en = 1'b0, grp_en = 1'b0;
  logic [4:0] lims [4];
  logic pwm_a_in = 1'b1, pwm_b_in = 1'b1;
  logic pwm_a_out, pwm_b_out;
  logic stat_rd = 1'b0;
  logic [2:0] stat_flags;
  logic [2:0] irq_en = '0;
  logic irq;

  int total = 0, bad = 0;
  int m_cnt [4];
  bit m_trip [4];
  bit done = 0;

  always #2 clk = ~clk;

  pwm_fault_latch dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .period_strobe(period_strobe),
    .flt_cl_in(fv[0]), .flt_ab_in(fv[1]), .flt_a_in(fv[2]), .flt_b_in(fv[3]),
    .cl_en(cl_en), .grp_en(grp_en),
    .lim_cl(lims[0]), .lim_ab(lims[1]), .lim_a(lims[2]), .lim_b(lims[3]),
    .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in), .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out),
    .stat_rd(stat_rd), .stat_flags(stat_flags), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_out(input bit is_a, input logic pin);
    bit kill;
    kill = m_trip[0] || m_trip[1] || (is_a ? m_trip[2] : m_trip[3]);
    return pin & chan_en & !kill;
  endfunction

  function automatic logic [2:0] exp_flags(input logic [3:0] f);
    return {f[1], f[3], f[2]} & {3{grp_en}};
  endfunction

  task automatic clear_model();
    for (int s = 0; s < 4; s++) begin m_cnt[s] = 0; m_trip[s] = 0; end
  endtask

  task automatic reenable();
    @(negedge clk) chan_en = 1'b0;
    @(negedge clk);
    @(negedge clk) chan_en = 1'b1;
    clear_model();
  endtask

  // one 12-cycle PWM period; flags read at cycle 0, two pulses per faulted source
  task automatic period(input logic [3:0] f, input string tag);
    logic [2:0] ef;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      stat_rd = (c == 0);
      fv = (c == 1 || c == 2 || c == 5 || c == 6) ? f : 4'b0;
      period_strobe = (c == 11);
    end
    @(negedge clk);
    stat_rd = 1'b0; fv = '0; period_strobe = 1'b0;
    for (int s = 0; s < 4; s++) begin
      bit en;
      en = (s == 0) ? cl_en : grp_en;
      if (f[s] && en) begin
        if (m_cnt[s] >= int'(lims[s])) m_trip[s] = 1;
        else m_cnt[s]++;
      end else m_cnt[s] = 0;
    end
    ef = exp_flags(f);
    chk({tag, " R6 out_a"}, pwm_a_out, exp_out(1, pwm_a_in));
    chk({tag, " R6 out_b"}, pwm_b_out, exp_out(0, pwm_b_in));
    chk({tag, " R8 flags"}, stat_flags, ef);
    chk({tag, " R10 irq"}, irq, |(ef & irq_en));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7151));
    for (int s = 0; s < 4; s++) lims[s] = 5'd31;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset flags", stat_flags, 3'b0);
    chk("R10 reset irq", irq, 1'b0);
    chk("R6 disabled outs low", {pwm_a_out, pwm_b_out}, 2'b00);
    @(negedge clk) chan_en = 1'b1;
    @(negedge clk);
    chk("R6 pass-through", {pwm_a_out, pwm_b_out}, 2'b11);

    cl_en = 1'b1; grp_en = 1'b1; irq_en = 3'b001;
    lims[2] = 5'd0;
    period(4'b0100, "lim0 A");
    chk("R5 limit 0 trips A", {pwm_a_out, pwm_b_out}, 2'b01);
    period(4'b0000, "clean");
    period(4'b0000, "clean");
    chk("R7 trip latched", pwm_a_out, 1'b0);
    reenable();
    @(negedge clk);
    chk("R7 restart after reenable", {pwm_a_out, pwm_b_out}, 2'b11);

    lims[2] = 5'd31; lims[3] = 5'd1;
    period(4'b1000, "B1");
    chk("R3 two events count once", pwm_b_out, 1'b1);
    period(4'b1000, "B2");
    chk("R5 limit 1 trips second period", pwm_b_out, 1'b0);
    reenable();

    lims[3] = 5'd31; lims[2] = 5'd2;
    period(4'b0100, "A1"); period(4'b0100, "A2");
    period(4'b0000, "gap");
    period(4'b0100, "A3"); period(4'b0100, "A4");
    chk("R4 clean period restarts run", pwm_a_out, 1'b1);
    period(4'b0100, "A5");
    chk("R5 limit 2 trips third in a row", pwm_a_out, 1'b0);
    reenable();

    lims[2] = 5'd31; lims[1] = 5'd0;
    period(4'b0010, "AB");
    chk("R6 both-output source", {pwm_a_out, pwm_b_out}, 2'b00);
    reenable();
    lims[1] = 5'd31; lims[0] = 5'd0; cl_en = 1'b0;
    period(4'b0001, "CL off");
    chk("R1 current-limit disabled", {pwm_a_out, pwm_b_out}, 2'b11);
    cl_en = 1'b1;
    period(4'b0001, "CL on");
    chk("R6 current-limit kills both", {pwm_a_out, pwm_b_out}, 2'b00);
    reenable();

    lims[0] = 5'd31; lims[2] = 5'd0; grp_en = 1'b0;
    period(4'b0100, "grp off");
    chk("R1 group disabled", {pwm_a_out, stat_flags}, {1'b1, 3'b000});
    grp_en = 1'b1; reenable();

    lims[2] = 5'd31;
    for (int p = 0; p < 31; p++) period(4'b0100, "run31");
    chk("R5 limit 31 holds 31 periods", pwm_a_out, 1'b1);
    period(4'b0100, "run32");
    chk("R5 limit 31 trips 32nd", pwm_a_out, 1'b0);
    reenable();

    // read and set in the same cycle
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    chk("R8 read clears", stat_flags, 3'b000);
    fv = 4'b0100;
    @(negedge clk);
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    chk("R9 set beats read", stat_flags[0], 1'b1);
    irq_en = 3'b001;
    chk("R10 irq from flag A", irq, 1'b1);
    irq_en = 3'b110;
    #0 chk("R10 irq masked", irq, 1'b0);
    fv = '0;
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    chk("R8 read clears after set", stat_flags, 3'b000);
    reenable();

    for (int p = 0; p < 80; p++) begin
      if (p % 10 == 0) begin
        for (int s = 0; s < 4; s++) lims[s] = 5'($urandom_range(0, 3));
        cl_en = 1'($urandom); grp_en = ($urandom_range(0, 3) != 0);
        irq_en = 3'($urandom);
      end
      if ($urandom_range(0, 7) == 0) reenable();
      pwm_a_in = ($urandom_range(0, 3) != 0);
      pwm_b_in = ($urandom_range(0, 3) != 0);
      period(4'($urandom) & 4'($urandom) | {3'b0, 1'b0}, "rand");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule